// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software by counting a 6-bit value down from 0x3F at a programmable rate. Software proves it is alive by writing a fixed 32-bit key into the refresh word. The refresh only counts when the counter has already fallen to or below a programmable window value. If software refreshes too early, or if it never refreshes and the counter reaches zero, the block issues a one-cycle system reset request. It also latches a sticky flag that software can read after the restart.

A compare flag marks the moment the counter enters the window. It can drive an interrupt, so software knows when a refresh has become legal. A debug input can freeze counting unless control says otherwise. The block sits on a simple synchronous register bus with four 32-bit words. The refresh word is at byte offset 0x0, control at 0x4, status at 0x8 and the counter readback at 0xC. Address bits 1:0 must be zero for an access to take effect.

Top module: `wdog_win_top`

## Requirements
- R1: After synchronous reset the control and status words read 0, the counter reads 0x3F, and both `irq_o` and `rst_req_o` are low.
- R2: Writing 0x00005AA5 to offset 0x0 while the block is enabled and the counter is at or below the window value reloads the counter to 0x3F and restarts the prescaler. Any other value written to offset 0x0 has no effect.
- R3: While enabled, the counter drops by one on each prescaler tick. A tick comes every 2^N clocks, where N is control bits 11:8.
- R4: When a tick takes the counter from 1 to 0, `rst_req_o` is high for exactly the next cycle and status bit 1 is set. The counter then stays at 0 until it is reloaded or disabled.
- R5: A key write while the counter is above the window value (control bits 21:16) raises `rst_req_o` for one cycle and sets status bit 1. It does not reload the counter.
- R6: Status bit 0 is set on the tick where the counter steps down to the window value, once per pass.
- R7: `irq_o` is high exactly when status bit 0 and control bit 1 are both 1.
- R8: Writing 1 to a status bit at offset 0x8 clears that bit, and writing 0 leaves it unchanged. If a set event falls in the same cycle as the clear, the bit ends up set.
- R9: While `dbg_mode` is high and control bit 31 is 0, the counter and prescaler hold their values. With bit 31 at 1, counting continues.
- R10: While control bit 0 is 0, the counter holds 0x3F and the prescaler is cleared. Key writes are ignored, and no reset request or flag set occurs.
- R11: Offset 0x0 reads 0. Offset 0x4 returns the control fields at bits 0, 1, 11:8, 21:16 and 31, with every other bit 0. Offset 0x8 returns the flags in bits 1:0. Offset 0xC returns the counter in bits 5:0. An access whose address bits 1:0 are not zero reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_mode | input | 1 | High while the system is halted for debug |
| irq_o | output | 1 | Window-entry interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can land in one clock edge. A counter event that sets a status flag can meet a software write-one-to-clear of that same flag. A valid key write can meet a prescaler tick. The bench provokes the first case by timing a clear of bit 0 to the exact cycle in which the counter steps from 6 to a window value of 5. It then expects the flag to read back set and the interrupt to stay high. A long pseudo-random phase mixes key writes, control rewrites, clears and debug toggles, and every cycle is compared against a behavioural model in which reload wins over a tick and a set wins over a clear.

// File: rtl/wdog_win_pkg.sv
package wdog_win_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 6;
    localparam int PSEL_W = 4;
    localparam int PRE_W  = (1 << PSEL_W) - 1;

    localparam logic [DATA_W-1:0] RELOAD_KEY = 32'h0000_5AA5;
    localparam logic [CNT_W-1:0]  CNT_MAX    = {CNT_W{1'b1}};

    // control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_PSEL_LSB = 8;
    localparam int CTRL_WIN_LSB  = 16;
    localparam int CTRL_DBG_BIT  = 31;

    // status word bit positions
    localparam int STAT_CMP_BIT = 0;
    localparam int STAT_RST_BIT = 1;

    // word index of each register (byte offset / 4)
    typedef enum logic [1:0] {
        SEL_KEY  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              dbg_run;
        logic [CNT_W-1:0]  win;
        logic [PSEL_W-1:0] psel;
        logic              ie;
        logic              en;
    } ctrl_t;

    typedef struct packed {
        logic rst_flag;
        logic cmp_flag;
    } stat_t;

    typedef struct packed {
        logic reload;
        logic early;
        logic expire;
        logic match;
    } evt_t;

    function automatic reg_sel_e reg_decode(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_encode(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT]                   = c.en;
        w[CTRL_IE_BIT]                   = c.ie;
        w[CTRL_PSEL_LSB +: PSEL_W]       = c.psel;
        w[CTRL_WIN_LSB +: CNT_W]         = c.win;
        w[CTRL_DBG_BIT]                  = c.dbg_run;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_encode(input stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STAT_CMP_BIT] = s.cmp_flag;
        w[STAT_RST_BIT] = s.rst_flag;
        return w;
    endfunction

endpackage

// File: rtl/wdog_win_regs.sv
module wdog_win_regs
    import wdog_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  evt_t              evt,
    output ctrl_t             ctrl_q,
    output stat_t             stat_q,
    output logic              key_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e sel;
    logic     aligned;
    logic     wr_ctrl;
    logic     wr_stat;
    logic     clr_cmp;
    logic     clr_rst;
    ctrl_t    ctrl_d;
    stat_t    stat_d;

    assign sel     = reg_decode(bus_addr);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ctrl = bus_we && aligned && (sel == SEL_CTRL);
    assign wr_stat = bus_we && aligned && (sel == SEL_STAT);
    assign key_wr  = bus_we && aligned && (sel == SEL_KEY) && (bus_wdata == RELOAD_KEY);
    assign clr_cmp = wr_stat && bus_wdata[STAT_CMP_BIT];
    assign clr_rst = wr_stat && bus_wdata[STAT_RST_BIT];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.en      = bus_wdata[CTRL_EN_BIT];
            ctrl_d.ie      = bus_wdata[CTRL_IE_BIT];
            ctrl_d.psel    = bus_wdata[CTRL_PSEL_LSB +: PSEL_W];
            ctrl_d.win     = bus_wdata[CTRL_WIN_LSB +: CNT_W];
            ctrl_d.dbg_run = bus_wdata[CTRL_DBG_BIT];
        end
    end

    // a set event from the counter outranks a software clear
    always_comb begin
        stat_d.cmp_flag = evt.match || (stat_q.cmp_flag && !clr_cmp);
        stat_d.rst_flag = evt.expire || evt.early || (stat_q.rst_flag && !clr_rst);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_KEY:  bus_rdata = '0;
                SEL_CTRL: bus_rdata = ctrl_encode(ctrl_q);
                SEL_STAT: bus_rdata = stat_encode(stat_q);
                SEL_CNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8
    cmp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_cmp && !evt.match) |=> !stat_q.cmp_flag);

    // R8
    cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_cmp && !evt.match) |=> $stable(stat_q.cmp_flag));

    // R6
    cmp_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.match |=> stat_q.cmp_flag);

    // R5
    rst_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.early || evt.expire) |=> stat_q.rst_flag);

endmodule

// File: rtl/wdog_win_prescaler.sv
module wdog_win_prescaler
    import wdog_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // mask holds the low psel bits; a tick falls when they are all ones
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (32'(psel) > i);
    end

    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && psel != '0) |=> (!tick || psel != $past(psel)));

    // R9
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pre_q));

endmodule

// File: rtl/wdog_win_counter.sv
module wdog_win_counter
    import wdog_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic             tick,
    input  logic             key_wr,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt_q,
    output evt_t             evt,
    output logic             rst_req_q
);

    logic             in_window;
    logic             dec;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] cnt_d;

    assign in_window  = (cnt_q <= win);
    assign cnt_dec    = cnt_q - 1'b1;

    assign evt.reload = en && key_wr && in_window;
    assign evt.early  = en && key_wr && !in_window;
    assign dec        = en && tick && (cnt_q != '0) && !evt.reload;
    assign evt.expire = dec && (cnt_q == CNT_W'(1));
    assign evt.match  = dec && (cnt_dec == win);

    always_comb begin
        if (!en || evt.reload) begin
            cnt_d = CNT_MAX;
        end else if (dec) begin
            cnt_d = cnt_dec;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= CNT_MAX;
            rst_req_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            rst_req_q <= evt.expire || evt.early;
        end
    end

    // R10
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == CNT_MAX && !rst_req_q));

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        evt.reload |=> (cnt_q == CNT_MAX));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !run && !evt.reload) |=> $stable(cnt_q));

    // R4
    expire_chk: assert property (@(posedge clk) disable iff (rst)
        evt.expire |=> (rst_req_q && cnt_q == '0));

    // R5
    early_chk: assert property (@(posedge clk) disable iff (rst)
        evt.early |=> rst_req_q);

endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
    import wdog_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_mode,
    output logic              irq_o,
    output logic              rst_req_o
);

    ctrl_t            ctrl;
    stat_t            stat;
    evt_t             evt;
    logic             key_wr;
    logic             run;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    assign run     = ctrl.en && (ctrl.dbg_run || !dbg_mode);
    assign restart = !ctrl.en || evt.reload;

    wdog_win_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt),
        .evt       (evt),
        .ctrl_q    (ctrl),
        .stat_q    (stat),
        .key_wr    (key_wr),
        .bus_rdata (bus_rdata)
    );

    wdog_win_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .psel    (ctrl.psel),
        .tick    (tick)
    );

    wdog_win_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .run       (run),
        .tick      (tick),
        .key_wr    (key_wr),
        .win       (ctrl.win),
        .cnt_q     (cnt),
        .evt       (evt),
        .rst_req_q (rst_req_o)
    );

    assign irq_o = stat.cmp_flag && ctrl.ie;

endmodule

// File: tb/wdog_win_top_tb_top.sv
`timescale 1ns/1ps
module wdog_win_top_tb_top;

    localparam logic [31:0] KEY = 32'h0000_5AA5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_mode = 1'b0;
    logic        irq_o;
    logic        rst_req_o;

    int n_checks = 0;
    int n_err    = 0;

    // behavioural reference state
    int m_en, m_ie, m_psel, m_win, m_dbgrun;
    int m_cnt, m_pre, m_if, m_rf, m_req;

    always #4 clk = ~clk;

    wdog_win_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_mode  (dbg_mode),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        logic [31:0] w;
        w = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (bus_addr[3:2])
                2'd1: w = (32'(m_dbgrun) << 31) | (32'(m_win) << 16) |
                          (32'(m_psel) << 8) | (32'(m_ie) << 1) | 32'(m_en);
                2'd2: w = (32'(m_rf) << 1) | 32'(m_if);
                2'd3: w = 32'(m_cnt);
                default: w = '0;
            endcase
        end
        return w;
    endfunction

    // advance the model by one edge using the inputs that were applied
    task automatic model_step();
        int  run, tick, key, reload, early, dec, match, expire;
        int  wr_stat, wr_ctrl, aligned, word;
        int  n_cnt, n_pre, n_if, n_rf;
        if (rst) begin
            m_en = 0; m_ie = 0; m_psel = 0; m_win = 0; m_dbgrun = 0;
            m_cnt = 63; m_pre = 0; m_if = 0; m_rf = 0; m_req = 0;
            return;
        end
        aligned = (bus_addr[1:0] == 2'b00);
        word    = int'(bus_addr[3:2]);
        wr_ctrl = bus_we && aligned && word == 1;
        wr_stat = bus_we && aligned && word == 2;
        key     = bus_we && aligned && word == 0 && bus_wdata == KEY;
        run     = m_en && (m_dbgrun || !dbg_mode);
        tick    = run && (((m_pre + 1) % (1 << m_psel)) == 0);
        reload  = m_en && key && (m_cnt <= m_win);
        early   = m_en && key && (m_cnt > m_win);
        dec     = m_en && tick && m_cnt != 0 && !reload;
        match   = dec && (m_cnt - 1 == m_win);
        expire  = dec && (m_cnt == 1);
        if (!m_en || reload) n_cnt = 63;
        else if (dec)        n_cnt = m_cnt - 1;
        else                 n_cnt = m_cnt;
        if (!m_en || reload) n_pre = 0;
        else if (run)        n_pre = (m_pre + 1) % 32768;
        else                 n_pre = m_pre;
        n_if = (match != 0) || (m_if && !(wr_stat && bus_wdata[0]));
        n_rf = (expire != 0) || (early != 0) || (m_rf && !(wr_stat && bus_wdata[1]));
        m_req = (expire || early) ? 1 : 0;
        m_cnt = n_cnt; m_pre = n_pre; m_if = n_if; m_rf = n_rf;
        if (wr_ctrl) begin
            m_en     = int'(bus_wdata[0]);
            m_ie     = int'(bus_wdata[1]);
            m_psel   = int'(bus_wdata[11:8]);
            m_win    = int'(bus_wdata[21:16]);
            m_dbgrun = int'(bus_wdata[31]);
        end
    endtask

    task automatic step();
        string rtag;
        @(posedge clk);
        #1;
        model_step();
        case (bus_addr[3:2])
            2'd2:    rtag = "R8 status readback";
            2'd3:    rtag = "R3 counter readback";
            default: rtag = "R11 readback";
        endcase
        chk(rtag, bus_rdata, exp_rdata());
        chk("R7 irq_o", 32'(irq_o), 32'((m_if != 0) && (m_ie != 0)));
        chk("R4 R5 rst_req_o", 32'(rst_req_o), 32'(m_req));
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        bus_addr = a;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst = 1'b1;
        idle(3, 4'hC);
        rst = 1'b0;
        // R1 reset state
        idle(1, 4'hC);
        chk("R1 counter after reset", bus_rdata, 32'h3F);
        chk("R1 irq after reset", 32'(irq_o), 0);
        chk("R1 rst_req after reset", 32'(rst_req_o), 0);
        idle(1, 4'h4);
        chk("R1 control after reset", bus_rdata, 0);
        idle(1, 4'h8);
        chk("R1 status after reset", bus_rdata, 0);

        // enable, tick every clock, window 0x30, interrupt on
        bus_write(4'h4, 32'h0030_0003);
        idle(15, 4'hC);
        chk("R6 counter at window", bus_rdata, 32'h30);
        chk("R7 irq on window entry", 32'(irq_o), 1);
        idle(1, 4'hC);
        chk("R6 flag sticky", 32'(irq_o), 1);

        // R2 wrong key has no effect
        bus_write(4'h0, 32'h1234_5678);
        idle(1, 4'hC);
        chk("R2 wrong key ignored", bus_rdata, 32'h2D);

        // R8 write 0 keeps, write 1 clears
        bus_write(4'h8, 32'h0);
        chk("R8 write zero keeps flag", bus_rdata, 32'h1);
        bus_write(4'h8, 32'h1);
        idle(1, 4'h8);
        chk("R8 write one clears flag", bus_rdata, 32'h0);
        chk("R7 irq follows flag", 32'(irq_o), 0);

        // R2 valid key inside window
        bus_write(4'h0, KEY);
        chk("R11 key word reads zero", bus_rdata, 32'h0);
        idle(1, 4'hC);
        chk("R2 reload to top", bus_rdata, 32'h3E);

        // R5 early refresh
        bus_write(4'h0, KEY);
        chk("R5 early refresh pulses", 32'(rst_req_o), 1);
        idle(1, 4'h8);
        chk("R4 pulse lasts one cycle", 32'(rst_req_o), 0);
        chk("R5 reset flag set", bus_rdata, 32'h2);
        idle(1, 4'hC);
        chk("R5 no reload on early key", bus_rdata, 32'h3B);
        bus_write(4'h8, 32'h2);

        // R3 prescale 2^3
        bus_write(4'h4, 32'h003F_0301);
        bus_write(4'h0, KEY);
        idle(7, 4'hC);
        chk("R3 no tick before period", bus_rdata, 32'h3F);
        idle(1, 4'hC);
        chk("R3 tick after 8 clocks", bus_rdata, 32'h3E);
        idle(8, 4'hC);
        chk("R3 second tick", bus_rdata, 32'h3D);

        // R9 debug freeze, then debug run
        dbg_mode = 1'b1;
        idle(20, 4'hC);
        chk("R9 frozen in debug", bus_rdata, 32'h3D);
        bus_write(4'h4, 32'h803F_0301);
        idle(8, 4'hC);
        chk("R9 counts in debug when allowed", bus_rdata, 32'h3C);
        dbg_mode = 1'b0;

        // same-cycle set and clear, then expiry
        bus_write(4'h4, 32'h003F_0003);
        bus_write(4'h0, KEY);
        bus_write(4'h4, 32'h0005_0003);
        idle(56, 4'hC);
        chk("R3 counter before window", bus_rdata, 32'h06);
        bus_write(4'h8, 32'h1);
        chk("R8 set wins over clear", bus_rdata, 32'h1);
        chk("R7 irq stays high", 32'(irq_o), 1);
        idle(4, 4'hC);
        chk("R4 counter at one", bus_rdata, 32'h01);
        idle(1, 4'hC);
        chk("R4 expiry pulse", 32'(rst_req_o), 1);
        chk("R4 counter at zero", bus_rdata, 32'h00);
        idle(1, 4'hC);
        chk("R4 pulse ends", 32'(rst_req_o), 0);
        chk("R4 counter holds zero", bus_rdata, 32'h00);
        idle(1, 4'h8);
        chk("R4 both flags set", bus_rdata, 32'h3);

        // R10 disabled
        bus_write(4'h4, 32'h0);
        bus_write(4'h0, KEY);
        chk("R10 no reset request when off", 32'(rst_req_o), 0);
        idle(10, 4'hC);
        chk("R10 counter held at top", bus_rdata, 32'h3F);
        idle(1, 4'h8);
        chk("R10 flags untouched", bus_rdata, 32'h3);
        bus_write(4'h8, 32'h3);
        idle(1, 4'h4);
        chk("R11 control reads zero", bus_rdata, 32'h0);

        // R11 unaligned access ignored
        bus_write(4'h5, 32'h0000_0001);
        idle(1, 4'h4);
        chk("R11 unaligned write ignored", bus_rdata, 32'h0);

        // mixed pseudo-random traffic against the model
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[3:0])
                4'd0: bus_write(4'h4, {lfsr[31], 9'b0, lfsr[21:16], 4'b0,
                                       2'b0, lfsr[9:8], 6'b0, lfsr[5], (lfsr[7:6] != 2'b00)});
                4'd1, 4'd2: bus_write(4'h0, KEY);
                4'd3: bus_write(lfsr[13:10], lfsr ^ 32'h0F0F_0000);
                4'd4: bus_write(4'h8, {30'b0, lfsr[5:4]});
                4'd5: begin
                    dbg_mode = lfsr[20];
                    idle(1, lfsr[13:10]);
                end
                default: idle(1, lfsr[13:10]);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule